// File: doc/BRIEF.md
# Parallel Panel Write Sequencer

This block pushes a frame of pixel words to a display panel that keeps its own frame memory. The panel link is a parallel 8080-style write bus: an active-low chip select, an active-low write strobe and a data bus. Each word goes out as one write cycle made of four programmable phases. The cycle opens with a chip-select lead-in, then a strobe lead-in, then the strobe-low interval, and ends with a trailing hold. Pixel words arrive on a valid/ready stream. Each word is accepted only when the sequencer is ready to start a new write cycle.

Software programs a timing/enable word and the display size, then issues a trigger command. Once a trigger is accepted, the block stays busy for the whole frame. Further triggers are dropped, because a repeated start could disturb the panel. At the end of the frame a sticky done flag is set, and the flag is cleared by a one-cycle clear pulse. When the done interrupt is enabled, the block stays busy until software clears the flag. When it is disabled, the block goes back to idle at once.

Top module: `pnl_wr_if`

## Requirements
- R1: The timing word holds an enable at bit 0, the hold length at [7:4], the strobe-low length at [11:8], the strobe lead-in at [15:12] and the chip-select lead-in at [19:16]. After reset its value is 0x00100: enable clear, strobe-low 1, all other phases 0.
- R2: A trigger write is accepted only when bits 0 and 1 of `trig_wdata` are both 1, the block is idle and the enable is set. Any other trigger write changes nothing. While the enable is clear, `px_ready` stays low and no write cycle appears.
- R3: In each write cycle `lcd_cs_n` is low for exactly cs_lead + wr_lead + A + hold cycles, where A = max(strobe-low, 1). `lcd_wr_n` is low for exactly A cycles. `lcd_wr_n` falls cs_lead + wr_lead cycles after `lcd_cs_n` falls. A phase programmed as 0 takes no cycle, except that the strobe-low phase always takes at least one.
- R4: `lcd_wr_n` is low only while `lcd_cs_n` is low.
- R5: `lcd_db` carries the word taken by the valid/ready handshake and stays unchanged for the whole time `lcd_cs_n` is low. Words are sent once each, in stream order.
- R6: `lcd_cs_n` is high for at least one cycle between write cycles. When the stream stalls, the next write cycle is only delayed.
- R7: A frame sends exactly `disp_w` × `disp_h` words. The size and the phase lengths are sampled when the trigger is accepted, so later changes do not affect the frame in progress.
- R8: A trigger accepted while a frame is busy is ignored, and the frame keeps its original length.
- R9: At the end of a frame `done_flag` is set and stays set until a `flag_clr` pulse. `irq` equals `done_flag` AND `irq_en`.
- R10: With `irq_en` set, `busy` stays high after the frame until the flag is cleared, and triggers are ignored in that interval. With `irq_en` clear, `busy` falls on the same edge that sets the flag, and the next trigger is accepted.
- R11: A frame whose size is zero sets `done_flag` without producing any write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the timing/enable word |
| cfg_wdata | input | 20 | Timing/enable word (fields in R1) |
| disp_w | input | DIM_W | Frame width in words |
| disp_h | input | DIM_W | Frame height in lines |
| trig_we | input | 1 | Trigger command write strobe |
| trig_wdata | input | 2 | Trigger command; both bits must be 1 |
| irq_en | input | 1 | Frame-done interrupt enable |
| flag_clr | input | 1 | Clear pulse for the done flag |
| px_valid | input | 1 | Pixel stream valid |
| px_ready | output | 1 | Pixel stream ready |
| px_data | input | DW | Pixel stream word |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_db | output | DW | Panel data bus |
| busy | output | 1 | Frame in progress or awaiting flag clear |
| done_flag | output | 1 | Sticky frame-done flag |
| irq | output | 1 | Frame-done interrupt |

## Verification
The bench walks a table of phase settings through the sequencer. The table includes all-zero phases, where a design that does not force a minimum strobe length would drop the strobe entirely, and maximum lead-in and hold values, where an off-by-one counter reload would stretch or shorten every cycle by one. It sends a second trigger halfway through a frame and another after the frame but before the flag is cleared. A design that restarted on either would send extra words or leave `busy` at the wrong level. It also changes the size and the timing in the middle of a frame, sends a zero-size frame, and sends triggers with only one command bit set. These cases catch a design that reads live settings, hangs waiting for a word that never comes, or treats a partial command as a start.

// File: rtl/pnl_wr_pkg.sv
package pnl_wr_pkg;
  localparam int CFG_W    = 20;
  localparam int PH_W     = 4;
  localparam int EN_BIT   = 0;
  localparam int HOLD_LSB = 4;
  localparam int ACT_LSB  = 8;
  localparam int WRS_LSB  = 12;
  localparam int CSS_LSB  = 16;
  localparam logic [CFG_W-1:0] CFG_RST = 20'h00100;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CSS, PH_WRS, PH_ACT, PH_HOLD
  } ph_e;

  typedef enum logic [1:0] {
    FR_IDLE, FR_RUN, FR_WAIT
  } fr_e;

  typedef struct packed {
    logic [PH_W-1:0] css;
    logic [PH_W-1:0] wrs;
    logic [PH_W-1:0] act;
    logic [PH_W-1:0] hold;
  } ph_cfg_t;
endpackage

// File: rtl/pnl_wr_regs.sv
module pnl_wr_regs
  import pnl_wr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             trig_we,
  input  logic [1:0]       trig_wdata,
  input  logic             flag_clr,
  input  logic             frame_end,
  output logic             en_o,
  output ph_cfg_t          tim_o,
  output logic             trig_req_o,
  output logic             flag_o
);
  logic    en_q;
  ph_cfg_t tim_q;
  logic    flag_q;
  logic    unused_bits;

  assign unused_bits = ^cfg_wdata[HOLD_LSB-1:EN_BIT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= CFG_RST[EN_BIT];
      tim_q.css  <= CFG_RST[CSS_LSB  +: PH_W];
      tim_q.wrs  <= CFG_RST[WRS_LSB  +: PH_W];
      tim_q.act  <= CFG_RST[ACT_LSB  +: PH_W];
      tim_q.hold <= CFG_RST[HOLD_LSB +: PH_W];
    end else if (cfg_we) begin
      en_q       <= cfg_wdata[EN_BIT];
      tim_q.css  <= cfg_wdata[CSS_LSB  +: PH_W];
      tim_q.wrs  <= cfg_wdata[WRS_LSB  +: PH_W];
      tim_q.act  <= cfg_wdata[ACT_LSB  +: PH_W];
      tim_q.hold <= cfg_wdata[HOLD_LSB +: PH_W];
    end
  end

  // set wins over clear so that a frame end is never lost
  always_ff @(posedge clk) begin
    if (rst)            flag_q <= 1'b0;
    else if (frame_end) flag_q <= 1'b1;
    else if (flag_clr)  flag_q <= 1'b0;
  end

  assign en_o       = en_q;
  assign tim_o      = tim_q;
  assign flag_o     = flag_q;
  assign trig_req_o = trig_we & trig_wdata[0] & trig_wdata[1] & en_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> flag_q); // R9
endmodule

// File: rtl/pnl_wr_frame.sv
module pnl_wr_frame
  import pnl_wr_pkg::*;
#(
  parameter int DIM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_req,
  input  logic             en,
  input  ph_cfg_t          tim_i,
  input  logic [DIM_W-1:0] disp_w,
  input  logic [DIM_W-1:0] disp_h,
  input  logic             irq_en,
  input  logic             flag_i,
  input  logic             flag_clr,
  input  logic             word_taken,
  input  logic             ph_idle,
  output logic             go_o,
  output ph_cfg_t          tim_o,
  output logic             busy_o,
  output logic             frame_end_o
);
  localparam int CNT_W = 2 * DIM_W;

  fr_e              st_q;
  logic [CNT_W-1:0] left_q;
  ph_cfg_t          tim_q;
  logic             frame_end;

  assign frame_end = (st_q == FR_RUN) && (left_q == '0) && ph_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= FR_IDLE;
      left_q <= '0;
      tim_q  <= '0;
    end else begin
      unique case (st_q)
        FR_IDLE: if (trig_req) begin
          left_q <= CNT_W'(disp_w) * CNT_W'(disp_h);
          tim_q  <= tim_i;
          st_q   <= FR_RUN;
        end
        FR_RUN: begin
          if (word_taken) left_q <= left_q - CNT_W'(1);
          if (frame_end)  st_q   <= irq_en ? FR_WAIT : FR_IDLE;
        end
        FR_WAIT: if (flag_clr) st_q <= FR_IDLE;
        default: st_q <= FR_IDLE;
      endcase
    end
  end

  assign go_o        = (st_q == FR_RUN) && (left_q != '0) && en;
  assign tim_o       = tim_q;
  assign busy_o      = (st_q != FR_IDLE);
  assign frame_end_o = frame_end;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    word_taken |-> (left_q != '0)); // R7

  AST_WAIT_FLAG: assert property (@(posedge clk) disable iff (rst)
    (st_q == FR_WAIT) |-> flag_i); // R10
endmodule

// File: rtl/pnl_wr_phase.sv
module pnl_wr_phase
  import pnl_wr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  ph_cfg_t       tim,
  input  logic          px_valid,
  input  logic [DW-1:0] px_data,
  output logic          px_ready,
  output logic          word_taken,
  output logic          idle_o,
  output logic          cs_n_o,
  output logic          wr_n_o,
  output logic [DW-1:0] db_o
);
  ph_e             ph_q, ph_d;
  logic [PH_W-1:0] cnt_q, cnt_d;
  logic [PH_W-1:0] act_eff;
  logic            cs_n_q, wr_n_q;
  logic [DW-1:0]   db_q;
  logic            take;

  assign act_eff  = (tim.act == '0) ? PH_W'(1) : tim.act;
  assign px_ready = (ph_q == PH_IDLE) && go;
  assign take     = px_ready && px_valid;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: if (take) begin
        if (tim.css != '0)      begin ph_d = PH_CSS; cnt_d = tim.css - PH_W'(1); end
        else if (tim.wrs != '0) begin ph_d = PH_WRS; cnt_d = tim.wrs - PH_W'(1); end
        else                    begin ph_d = PH_ACT; cnt_d = act_eff - PH_W'(1); end
      end
      PH_CSS: if (cnt_q != '0) cnt_d = cnt_q - PH_W'(1);
        else if (tim.wrs != '0) begin ph_d = PH_WRS; cnt_d = tim.wrs - PH_W'(1); end
        else                    begin ph_d = PH_ACT; cnt_d = act_eff - PH_W'(1); end
      PH_WRS: if (cnt_q != '0) cnt_d = cnt_q - PH_W'(1);
        else begin ph_d = PH_ACT; cnt_d = act_eff - PH_W'(1); end
      PH_ACT: if (cnt_q != '0) cnt_d = cnt_q - PH_W'(1);
        else if (tim.hold != '0) begin ph_d = PH_HOLD; cnt_d = tim.hold - PH_W'(1); end
        else                     ph_d = PH_IDLE;
      PH_HOLD: if (cnt_q != '0) cnt_d = cnt_q - PH_W'(1);
        else ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      cs_n_q <= 1'b1;
      wr_n_q <= 1'b1;
      db_q   <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      cs_n_q <= (ph_d == PH_IDLE);
      wr_n_q <= (ph_d != PH_ACT);
      if (take) db_q <= px_data;
    end
  end

  assign word_taken = take;
  assign idle_o     = (ph_q == PH_IDLE);
  assign cs_n_o     = cs_n_q;
  assign wr_n_o     = wr_n_q;
  assign db_o       = db_q;

  AST_WR_IN_CS: assert property (@(posedge clk) disable iff (rst)
    !wr_n_q |-> !cs_n_q); // R4

  AST_DB_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_q && $past(!cs_n_q)) |-> $stable(db_q)); // R5
endmodule

// File: rtl/pnl_wr_if.sv
module pnl_wr_if
  import pnl_wr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DIM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [19:0]      cfg_wdata,
  input  logic [DIM_W-1:0] disp_w,
  input  logic [DIM_W-1:0] disp_h,
  input  logic             trig_we,
  input  logic [1:0]       trig_wdata,
  input  logic             irq_en,
  input  logic             flag_clr,
  input  logic             px_valid,
  output logic             px_ready,
  input  logic [DW-1:0]    px_data,
  output logic             lcd_cs_n,
  output logic             lcd_wr_n,
  output logic [DW-1:0]    lcd_db,
  output logic             busy,
  output logic             done_flag,
  output logic             irq
);
  logic    en, trig_req, flag, frame_end, go, word_taken, ph_idle;
  ph_cfg_t tim_reg, tim_run;

  pnl_wr_regs u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .trig_we(trig_we), .trig_wdata(trig_wdata), .flag_clr(flag_clr),
    .frame_end(frame_end), .en_o(en), .tim_o(tim_reg),
    .trig_req_o(trig_req), .flag_o(flag)
  );

  pnl_wr_frame #(.DIM_W(DIM_W)) u_frame (
    .clk(clk), .rst(rst), .trig_req(trig_req), .en(en), .tim_i(tim_reg),
    .disp_w(disp_w), .disp_h(disp_h), .irq_en(irq_en), .flag_i(flag),
    .flag_clr(flag_clr), .word_taken(word_taken), .ph_idle(ph_idle),
    .go_o(go), .tim_o(tim_run), .busy_o(busy), .frame_end_o(frame_end)
  );

  pnl_wr_phase #(.DW(DW)) u_phase (
    .clk(clk), .rst(rst), .go(go), .tim(tim_run), .px_valid(px_valid),
    .px_data(px_data), .px_ready(px_ready), .word_taken(word_taken),
    .idle_o(ph_idle), .cs_n_o(lcd_cs_n), .wr_n_o(lcd_wr_n), .db_o(lcd_db)
  );

  assign done_flag = flag;
  assign irq       = flag & irq_en;

  AST_NO_ISSUE_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |-> !px_ready); // R2
endmodule

// File: tb/tb_pnl_wr_if.sv
module tb_pnl_wr_if;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DIM_W = 8;
  localparam int NV = 6;
  // [27:24] cs lead, [23:20] wr lead, [19:16] strobe, [15:12] hold,
  // [11:8] width, [7:4] height, [0] stall stream
  localparam logic [27:0] VEC [NV] = '{
    28'h0010_220, 28'h1234_310, 28'h0000_131,
    28'hF02F_210, 28'h2001_221, 28'h0350_110};

  logic clk = 0, rst = 1;
  logic cfg_we = 0; logic [19:0] cfg_wdata = 0;
  logic [DIM_W-1:0] disp_w = 0, disp_h = 0;
  logic trig_we = 0; logic [1:0] trig_wdata = 0;
  logic irq_en = 0, flag_clr = 0, px_valid = 0;
  logic px_ready; logic [DW-1:0] px_data = 0;
  logic lcd_cs_n, lcd_wr_n, busy, done_flag, irq;
  logic [DW-1:0] lcd_db;

  pnl_wr_if #(.DW(DW), .DIM_W(DIM_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, fails = 0, cyc = 0;
  int rec_n = 0, rec_cs[64], rec_wr[64], rec_pre[64], rec_post[64];
  int rec_db[64];
  int cs_cnt = 0, wr_cnt = 0, pre_cnt = 0, post_cnt = 0, stable_err = 0;
  bit seen_wr = 0, prev_cs_low = 0;
  logic [DW-1:0] prev_db = 0, cap_db = 0;
  bit feed_on = 0, feed_stall = 0, stall_tog = 0, hs_pend = 0;
  int feed_idx = 0; logic [DW-1:0] feed_base = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; total++;
      $display("FAIL watchdog: got %0d expected below 150000 cycles", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // stream source
  always @(negedge clk) begin
    if (hs_pend) feed_idx++;
    stall_tog = ~stall_tog;
    px_valid = feed_on && !(feed_stall && stall_tog);
    px_data = feed_base + DW'(feed_idx);
    hs_pend = px_valid && px_ready;
  end

  // panel-side monitor
  always @(negedge clk) begin
    if (!lcd_cs_n) begin
      cs_cnt++;
      if (prev_cs_low && lcd_db != prev_db) stable_err++;
      if (!lcd_wr_n) begin wr_cnt++; seen_wr = 1; cap_db = lcd_db; end
      else if (!seen_wr) pre_cnt++;
      else post_cnt++;
    end else if (prev_cs_low) begin
      if (rec_n < 64) begin
        rec_cs[rec_n] = cs_cnt; rec_wr[rec_n] = wr_cnt;
        rec_pre[rec_n] = pre_cnt; rec_post[rec_n] = post_cnt;
        rec_db[rec_n] = int'(cap_db);
      end
      rec_n++;
      cs_cnt = 0; wr_cnt = 0; pre_cnt = 0; post_cnt = 0; seen_wr = 0;
    end
    prev_cs_low = !lcd_cs_n;
    prev_db = lcd_db;
  end

  task automatic cfg_write(input logic [19:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic trigger(input logic [1:0] v);
    @(negedge clk); trig_we = 1; trig_wdata = v;
    @(negedge clk); trig_we = 0; trig_wdata = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic start_feed(input logic [DW-1:0] base, input bit stall);
    @(negedge clk);
    feed_base = base; feed_idx = 0; feed_stall = stall; feed_on = 1;
    rec_n = 0;
  endtask

  task automatic wait_flag(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done_flag) begin ok = 1; break; end
    end
  endtask

  task automatic idle_for(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_words(input string req, input int css, input int wrs,
                             input int act, input int hold, input int n,
                             input logic [DW-1:0] base);
    int ae, e;
    ae = (act == 0) ? 1 : act;
    e = css + wrs + ae + hold;
    chk(rec_n == n, "R7", "word count", rec_n, n);
    for (int i = 0; i < n && i < rec_n; i++) begin
      chk(rec_cs[i] == e, "R3", "cs low cycles", rec_cs[i], e);
      chk(rec_wr[i] == ae, "R3", "wr low cycles", rec_wr[i], ae);
      chk(rec_pre[i] == css + wrs, "R3", "lead before wr", rec_pre[i], css + wrs);
      chk(rec_post[i] == hold, req, "hold after wr", rec_post[i], hold);
      chk(rec_db[i] == int'(base) + i, "R5", "data word", rec_db[i], int'(base) + i);
    end
  endtask

  initial begin
    bit ok;
    logic [27:0] v;
    logic [DW-1:0] base;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state, R1 / R2
    chk(lcd_cs_n == 1, "R1", "cs_n after reset", int'(lcd_cs_n), 1);
    chk(lcd_wr_n == 1, "R1", "wr_n after reset", int'(lcd_wr_n), 1);
    chk(busy == 0 && done_flag == 0 && irq == 0, "R1", "status after reset",
        int'({busy, done_flag, irq}), 0);
    disp_w = 2; disp_h = 1;
    start_feed(16'h0050, 0);
    trigger(2'b11);
    idle_for(20);
    chk(busy == 0 && rec_n == 0 && px_ready == 0, "R2", "trigger with reset enable",
        rec_n + int'(busy), 0);

    // table walk: R3 R5 R6 R9 R10
    irq_en = 1;
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      base = DW'(16'h0100 * (k + 1));
      cfg_write({v[27:24], v[23:20], v[19:16], v[15:12], 4'h1});
      disp_w = DIM_W'(v[11:8]); disp_h = DIM_W'(v[7:4]);
      start_feed(base, v[0]);
      trigger(2'b11);
      wait_flag(ok);
      chk(ok, "R9", "flag raised", int'(ok), 1);
      chk(busy == 1 && irq == 1, "R10", "busy and irq at flag", int'({busy, irq}), 3);
      check_words("R6", int'(v[27:24]), int'(v[23:20]), int'(v[19:16]),
                  int'(v[15:12]), int'(v[11:8]) * int'(v[7:4]), base);
      clear_flag();
      @(negedge clk);
      chk(done_flag == 0 && busy == 0, "R10", "cleared", int'({busy, done_flag}), 0);
    end
    chk(stable_err == 0, "R5", "data stable while cs low", stable_err, 0);

    // partial trigger commands, R2
    cfg_write(20'h00101); disp_w = 2; disp_h = 1;
    start_feed(16'h0700, 0);
    trigger(2'b10); trigger(2'b01);
    idle_for(10);
    chk(busy == 0 && rec_n == 0, "R2", "partial command ignored", rec_n + int'(busy), 0);

    // re-trigger mid-frame and before clear, R8 / R10
    cfg_write(20'h21211); disp_w = 4; disp_h = 1;
    start_feed(16'h0800, 0);
    trigger(2'b11);
    idle_for(8);
    trigger(2'b11);
    wait_flag(ok);
    trigger(2'b11);
    idle_for(30);
    chk(rec_n == 4, "R8", "words with re-triggers", rec_n, 4);
    chk(busy == 1, "R10", "busy held until clear", int'(busy), 1);
    check_words("R8", 2, 1, 2, 1, 4, 16'h0800);
    clear_flag();

    // mid-frame size and timing change, R7
    cfg_write(20'h21211); disp_w = 3; disp_h = 1;
    start_feed(16'h0900, 0);
    trigger(2'b11);
    idle_for(4);
    disp_w = 1;
    cfg_write(20'h00101);
    wait_flag(ok);
    check_words("R7", 2, 1, 2, 1, 3, 16'h0900);
    clear_flag();

    // interrupt disabled: immediate idle and next trigger accepted, R10
    irq_en = 0;
    cfg_write(20'h00101); disp_w = 2; disp_h = 1;
    start_feed(16'h0A00, 0);
    trigger(2'b11);
    wait_flag(ok);
    chk(busy == 0 && irq == 0, "R10", "busy/irq at flag, irq off", int'({busy, irq}), 0);
    start_feed(16'h0B00, 0);
    trigger(2'b11);
    idle_for(30);
    chk(rec_n == 2, "R10", "trigger accepted with flag pending", rec_n, 2);
    chk(done_flag == 1 && irq == 0, "R9", "irq gated by enable", int'({done_flag, irq}), 2);
    clear_flag();
    @(negedge clk);
    chk(done_flag == 0, "R9", "flag clear pulse", int'(done_flag), 0);

    // zero-size frame, R11
    disp_w = 0; disp_h = 5;
    start_feed(16'h0C00, 0);
    trigger(2'b11);
    wait_flag(ok);
    idle_for(5);
    chk(ok && rec_n == 0, "R11", "zero frame done without writes", rec_n, 0);
    chk(stable_err == 0, "R5", "final data stability", stable_err, 0);
    clear_flag();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule